// File: doc/BRIEF.md
# Latin-Square Majority-Logic Data Decoder

This block decodes a word protected by an orthogonal Latin squares code. The code carries k = m² data bits and 2tm check bits, where t is the number of errors it corrects. The block recomputes every parity check from the received data bits and compares each one with the received check bit. The result is a syndrome vector with one bit per check.

Each data bit takes part in exactly 2t checks, one in each check group. Any two data bits share at most one check. Because of this, each data bit can be corrected on its own by a one-step majority vote over its 2t syndrome bits. No syndrome lookup table is needed. The block sits on the read path of a protected memory or link. It returns the corrected data word and a flag that shows a mismatch was seen.

The default code corrects double errors: m = 4, t = 2, 16 data bits and 16 check bits. The outputs can be registered (default) or taken straight from the logic. Check bits are not corrected.

Top module: `ols_mlg_decoder`

## Requirements
- R1: Data bit i is split as r = i div m and c = i mod m. In check group g it uses check index `g*m + p`. The position p within the group is r for g=0 and c for g=1. For g≥2 it is r XOR (g−1)·c, with the product taken in GF(m), which for m=4 uses x²+x+1. Check bits sit at chk_i bit positions 0..2tm−1. With a consistent codeword, data_o equals the transmitted data and err_o is 0.
- R2: A single flipped bit anywhere in the data word or the check word leaves data_o equal to the transmitted data.
- R3: Any two flipped bits, in any mix of data and check positions, leave data_o equal to the transmitted data.
- R4: err_o is 1 exactly when at least one recomputed check differs from its received check bit. It is therefore 1 for every one- or two-bit error pattern and 0 for a consistent codeword.
- R5: A data bit is inverted when at least t+1 of its 2t checks mismatch. Flipping t+1 of data bit i's check bits inverts bit i of data_o and no other bit.
- R6: Exactly t mismatching checks of a data bit do not invert it. Flipping t of its check bits leaves data_o equal to the transmitted data.
- R7: With REG_OUT=1, data_o and err_o show the result for the inputs present at a rising clock edge, from that edge onward. While rst_ni is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | M*M | Received data word |
| chk_i | input | 2*T*M | Received check word |
| data_o | output | M*M | Corrected data word |
| err_o | output | 1 | Any syndrome bit set |

## Verification
The assertions assume the inputs are known, two-state values. The syndrome parity check also assumes every data bit sits in an even number of checks, which holds because there are 2t groups. The bench drives only valid codewords, built by its own encoder from the R1 index rule, with a chosen error mask applied on top. Each input is held from one falling edge to the next, so every rising edge sees one settled word. The patterns cover no error, all single and all double errors on three data words, and t and t+1 check-bit flips aimed at each data bit.

// File: rtl/ols_pkg.sv
package ols_pkg;

  // GF(2^mb) multiply, primitive polynomial picked by field size
  function automatic int gf_mul(input int a, input int b, input int mb);
    int poly;
    int acc;
    int x;
    case (mb)
      1:       poly = 3;
      2:       poly = 7;
      3:       poly = 11;
      4:       poly = 19;
      default: poly = 37;
    endcase
    acc = 0;
    x   = a;
    for (int n = 0; n < mb; n++) begin
      if (((b >> n) & 1) != 0) acc = acc ^ x;
      x = x << 1;
      if (((x >> mb) & 1) != 0) x = x ^ poly;
    end
    return acc;
  endfunction

  // Position of data bit i inside check group g
  function automatic int grp_pos(input int g, input int i, input int m, input int mb);
    int r;
    int c;
    r = i / m;
    c = i % m;
    if (g == 0) return r;
    if (g == 1) return c;
    return r ^ gf_mul(g - 1, c, mb);
  endfunction

endpackage

// File: rtl/ols_check_gen.sv
module ols_check_gen #(
  parameter int M = 4,
  parameter int T = 2
) (
  input  logic [M*M-1:0]   data_i,
  output logic [2*T*M-1:0] chk_o
);
  import ols_pkg::*;

  localparam int K  = M * M;
  localparam int G  = 2 * T;
  localparam int MB = $clog2(M);

  for (genvar g = 0; g < G; g++) begin : g_grp
    for (genvar p = 0; p < M; p++) begin : g_pos
      always_comb begin
        chk_o[g*M+p] = 1'b0;
        for (int i = 0; i < K; i++) begin
          if (grp_pos(g, i, M, MB) == p) chk_o[g*M+p] = chk_o[g*M+p] ^ data_i[i];
        end
      end
    end
  end

endmodule

// File: rtl/ols_syndrome.sv
module ols_syndrome #(
  parameter int M = 4,
  parameter int T = 2
) (
  input  logic [M*M-1:0]   data_i,
  input  logic [2*T*M-1:0] chk_i,
  output logic [2*T*M-1:0] synd_o
);

  logic [2*T*M-1:0] recomp;

  ols_check_gen #(.M(M), .T(T)) i_gen (
    .data_i (data_i),
    .chk_o  (recomp)
  );

  assign synd_o = recomp ^ chk_i;

  // R1: each data bit feeds an even count (2t) of checks, so syndrome parity tracks received check parity
  always_comb begin
    if (!$isunknown({data_i, chk_i})) begin
      synd_parity_chk: assert ((^synd_o) == (^chk_i))
        else $error("syndrome parity mismatch");
    end
  end

endmodule

// File: rtl/ols_vote.sv
module ols_vote #(
  parameter int M = 4,
  parameter int T = 2
) (
  input  logic [M*M-1:0]   data_i,
  input  logic [2*T*M-1:0] synd_i,
  output logic [M*M-1:0]   data_o
);
  import ols_pkg::*;

  localparam int K  = M * M;
  localparam int G  = 2 * T;
  localparam int C  = G * M;
  localparam int MB = $clog2(M);
  localparam int CW = $clog2(G + 1);

  logic [K-1:0] flip;

  for (genvar i = 0; i < K; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int g = 0; g < G; g++) begin
        cnt = cnt + CW'(synd_i[g*M + grp_pos(g, i, M, MB)]);
      end
    end
    assign flip[i] = (cnt >= CW'(T + 1));
  end

  assign data_o = data_i ^ flip;

  always_comb begin
    if (!$isunknown({data_i, synd_i})) begin
      // R1
      clean_pass_chk: assert ((synd_i != '0) || (data_o == data_i))
        else $error("data altered with zero syndrome");
      // R5: every inverted bit needs t+1 set syndromes, each syndrome serves m bits
      flip_bound_chk: assert ($countones(data_o ^ data_i) * (T + 1) <= $countones(synd_i) * M)
        else $error("more bits inverted than syndromes allow");
    end
  end

endmodule

// File: rtl/ols_mlg_decoder.sv
module ols_mlg_decoder #(
  parameter int M       = 4,
  parameter int T       = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [M*M-1:0]     data_i,
  input  logic [2*T*M-1:0]   chk_i,
  output logic [M*M-1:0]     data_o,
  output logic               err_o
);

  localparam int K = M * M;
  localparam int C = 2 * T * M;

  logic [C-1:0] synd;
  logic [K-1:0] fixed;
  logic         any_err;

  ols_syndrome #(.M(M), .T(T)) i_synd (
    .data_i (data_i),
    .chk_i  (chk_i),
    .synd_o (synd)
  );

  ols_vote #(.M(M), .T(T)) i_vote (
    .data_i (data_i),
    .synd_i (synd),
    .data_o (fixed)
  );

  assign any_err = |synd;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o <= '0;
        err_o  <= 1'b0;
      end else begin
        data_o <= fixed;
        err_o  <= any_err;
      end
    end

    // R7
    quiet_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_err |=> !err_o)
      else $error("flag raised without mismatch");
    // R7
    quiet_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_err |=> (data_o == $past(data_i)))
      else $error("clean word not passed through");
  end else begin : g_comb
    assign data_o = fixed;
    assign err_o  = any_err;
  end

endmodule

// File: tb/test_ols_mlg_decoder.sv
`timescale 1ns/1ps
module test_ols_mlg_decoder;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] chk_i = '0;
  logic [15:0] data_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] d;
    logic        e;
    string       req;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  ols_mlg_decoder i_ols_mlg_decoder (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .chk_i  (chk_i),
    .data_o (data_o),
    .err_o  (err_o)
  );

  function automatic int pos(input int g, input int i);
    int r;
    int c;
    int c2;
    r = i / 4;
    c = i % 4;
    case (c)
      0: c2 = 0;
      1: c2 = 2;
      2: c2 = 3;
      default: c2 = 1;
    endcase
    case (g)
      0: return r;
      1: return c;
      2: return r ^ c;
      default: return r ^ c2;
    endcase
  endfunction

  function automatic logic [15:0] enc(input logic [15:0] d);
    logic [15:0] k;
    k = '0;
    for (int i = 0; i < 16; i++)
      for (int g = 0; g < 4; g++)
        k[g*4 + pos(g, i)] ^= d[i];
    return k;
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b",
               req, act[15:0], act[16], exp[15:0], exp[16]);
    end
  endtask

  task automatic drive(input logic [15:0] d, input logic [31:0] emask,
                       input logic [15:0] exp_d, input logic exp_e, input string req);
    logic [31:0] w;
    exp_t it;
    w = {enc(d), d} ^ emask;
    @(negedge clk);
    data_i = w[15:0];
    chk_i  = w[31:16];
    it.d = exp_d;
    it.e = exp_e;
    it.req = req;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.req, {err_o, data_o}, {it.e, it.d});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] words [3];
    words[0] = 16'h0000;
    words[1] = 16'hffff;
    words[2] = 16'ha5c3;

    // R7: reset state
    data_i = 16'h1234;
    chk_i  = 16'hbeef;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", {err_o, data_o}, 17'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: clean codewords
    for (int w = 0; w < 3; w++) drive(words[w], 32'h0, words[w], 1'b0, "R1 clean");
    drive(16'h8001, 32'h0, 16'h8001, 1'b0, "R1 clean");

    // R2 / R4: every single error
    for (int w = 0; w < 3; w++)
      for (int a = 0; a < 32; a++)
        drive(words[w], 32'h1 << a, words[w], 1'b1, "R2 single");

    // R3 / R4: every double error
    for (int w = 0; w < 3; w++)
      for (int a = 0; a < 32; a++)
        for (int b = a + 1; b < 32; b++)
          drive(words[w], (32'h1 << a) | (32'h1 << b), words[w], 1'b1, "R3 double");

    // R5 / R6: aimed check-bit flips
    for (int i = 0; i < 16; i++) begin
      logic [31:0] m3;
      logic [31:0] m2;
      m2 = (32'h1 << (16 + 0*4 + pos(0, i))) | (32'h1 << (16 + 1*4 + pos(1, i)));
      m3 = m2 | (32'h1 << (16 + 2*4 + pos(2, i)));
      drive(words[2], m3, words[2] ^ (16'h1 << i), 1'b1, "R5 t+1 flips");
      drive(words[2], m2, words[2], 1'b1, "R6 t flips");
    end

    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule